// File: doc/BRIEF.md
# Masked Quadword Vector Permute Unit

This block rearranges the 64-bit elements of a vector image of up to 512 bits into a new destination vector. The selection of source elements comes from one of two places. In control-byte mode, a single byte holds four 2-bit selectors, and that byte steers each 256-bit half separately. In index-vector mode, a second vector carries one index per destination element, and that index may reach any element of the active source. A source element may be picked by any number of destination elements.

Before the permutation, a memory-sourced operand can be widened from its low 64 bits to every element. After the permutation, a per-element write mask decides element by element: keep the permuted value, keep the previous destination value (merge), or clear it (zero). Everything above the active length is cleared. The block also checks the encoding it is handed. A bad vector length, or a bad reserved field in control-byte mode, raises an illegal flag. When that happens the old destination comes back unchanged and no write enable is given. The result is registered, so it appears one clock after the input strobe.

Top module: `qperm_unit`

## Requirements
- R1: In control-byte mode (ctl_mode=0), destination element n of the low half (n=0..3) equals source element ctl_byte[2n+1:2n].
- R2: In control-byte mode at 512-bit length, destination element 4+n equals source element 4+ctl_byte[2n+1:2n]. The same byte serves both halves, and the upper half draws only from source elements 4..7.
- R3: In index-vector mode (ctl_mode=1), destination element j is taken from bits [2:0] of index element j at 512-bit length. At 256-bit length only bits [1:0] are used, so the pick is among elements 0..3. All other index bits are ignored.
- R4: When both bcast and src_is_mem are 1, every source element is replaced by src_vec[63:0] before selection. If either one is 0, the source is used as given.
- R5: For each active element j, the permuted value is written when mask_en=0 or wmask[j]=1. Otherwise the element takes old_dst element j when zero_mode=0, or 0 when zero_mode=1.
- R6: vlen=2'b01 selects 256 bits and vlen=2'b10 selects 512 bits. On a legal operation, every output bit at or above the active length is 0, whatever the mask mode.
- R7: vlen=2'b00 (128 bits) and vlen=2'b11 are illegal and set out_illegal.
- R8: In control-byte mode, rsv_spec other than 4'b1111 is illegal. In index-vector mode, rsv_spec has no effect.
- R9: On an illegal operation, out_vec equals old_dst and out_wen is 0. On a legal operation, out_wen is 1 and out_illegal is 0.
- R10: out_valid, out_vec, out_wen and out_illegal update one clock after an in_valid strobe. out_valid is high exactly in the cycles that follow an in_valid cycle. out_vec holds between strobes. After reset, all outputs are 0.
- R11: No uniqueness check is made on selections. One source element may appear in several destination elements, for example ctl_byte=8'h00 copies element 0 to all of 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| ctl_mode | input | 1 | 0 = control-byte mode, 1 = index-vector mode |
| ctl_byte | input | 8 | Four 2-bit selectors |
| idx_vec | input | 512 | Per-element indices |
| src_vec | input | 512 | Source elements |
| bcast | input | 1 | Broadcast request |
| src_is_mem | input | 1 | Source came from memory |
| wmask | input | 8 | Per-element write mask |
| mask_en | input | 1 | Enables the write mask |
| zero_mode | input | 1 | 1 = clear unselected elements, 0 = merge |
| old_dst | input | 512 | Previous destination value |
| vlen | input | 2 | Vector length code |
| rsv_spec | input | 4 | Reserved register-specifier field |
| out_valid | output | 1 | Result strobe |
| out_vec | output | 512 | Result vector |
| out_wen | output | 1 | Destination write enable |
| out_illegal | output | 1 | Illegal-encoding flag |

## Verification
The properties take for granted that every input is stable and known in a cycle where in_valid is high. They also assume that old_dst is the value the destination register really holds, since the hold-on-illegal and merge checks compare against it. The stimulus only changes inputs on the falling edge and raises in_valid together with a fully defined operand set. Reset is held with in_valid low, so no strobe is seen before the first legal clock edge.

// File: rtl/qperm_pkg.sv
package qperm_pkg;
   typedef enum logic [1:0] {
      VL_NARROW = 2'b00,
      VL_HALF   = 2'b01,
      VL_FULL   = 2'b10,
      VL_RSVD   = 2'b11
   } vlen_e;

   typedef enum logic {
      MODE_CTLBYTE = 1'b0,
      MODE_INDEX   = 1'b1
   } ctl_mode_e;

   localparam logic [3:0] RSV_EXPECT = 4'b1111;
endpackage

// File: rtl/qperm_bcast.sv
module qperm_bcast #(
   parameter int ELEM_W    = 64,
   parameter int NUM_ELEMS = 8,
   localparam int VEC_W    = ELEM_W * NUM_ELEMS
) (
   input  logic [VEC_W-1:0] src_vec,
   input  logic             bcast,
   input  logic             src_is_mem,
   output logic [VEC_W-1:0] eff_src
);
   logic do_rep;
   assign do_rep = bcast & src_is_mem;

   for (genvar j = 0; j < NUM_ELEMS; j++) begin : g_elem
      if (j == 0) begin : g_base
         assign eff_src[ELEM_W-1:0] = src_vec[ELEM_W-1:0];
      end else begin : g_rep
         assign eff_src[j*ELEM_W +: ELEM_W] =
            do_rep ? src_vec[ELEM_W-1:0] : src_vec[j*ELEM_W +: ELEM_W];
      end
   end
endmodule

// File: rtl/qperm_selgen.sv
module qperm_selgen
   import qperm_pkg::*;
#(
   parameter int ELEM_W     = 64,
   parameter int HALF_ELEMS = 4,
   localparam int NUM_ELEMS = 2 * HALF_ELEMS,
   localparam int VEC_W     = ELEM_W * NUM_ELEMS,
   localparam int SEL_W     = $clog2(HALF_ELEMS),
   localparam int IDX_W     = SEL_W + 1,
   localparam int CTL_W     = SEL_W * HALF_ELEMS
) (
   input  logic                       ctl_mode,
   input  logic                       full_len,
   input  logic [CTL_W-1:0]           ctl_byte,
   input  logic [VEC_W-1:0]           idx_vec,
   output logic [NUM_ELEMS*IDX_W-1:0] sel_flat
);
   for (genvar j = 0; j < NUM_ELEMS; j++) begin : g_sel
      localparam int HALF_NO = j / HALF_ELEMS;
      localparam int POS     = j % HALF_ELEMS;
      logic [IDX_W-1:0] byte_sel;
      logic [IDX_W-1:0] wide_sel;
      logic [IDX_W-1:0] narrow_sel;

      assign byte_sel   = {1'(HALF_NO), ctl_byte[POS*SEL_W +: SEL_W]};
      assign wide_sel   = idx_vec[j*ELEM_W +: IDX_W];
      assign narrow_sel = {1'b0, idx_vec[j*ELEM_W +: SEL_W]};

      always_comb begin
         if (ctl_mode == MODE_INDEX)
            sel_flat[j*IDX_W +: IDX_W] = full_len ? wide_sel : narrow_sel;
         else
            sel_flat[j*IDX_W +: IDX_W] = byte_sel;
      end
   end
endmodule

// File: rtl/qperm_xbar.sv
module qperm_xbar #(
   parameter int ELEM_W    = 64,
   parameter int NUM_ELEMS = 8,
   localparam int VEC_W    = ELEM_W * NUM_ELEMS,
   localparam int IDX_W    = $clog2(NUM_ELEMS)
) (
   input  logic [VEC_W-1:0]           src,
   input  logic [NUM_ELEMS*IDX_W-1:0] sel_flat,
   output logic [VEC_W-1:0]           perm
);
   logic [ELEM_W-1:0] src_arr [NUM_ELEMS];

   for (genvar k = 0; k < NUM_ELEMS; k++) begin : g_unpack
      assign src_arr[k] = src[k*ELEM_W +: ELEM_W];
   end

   for (genvar j = 0; j < NUM_ELEMS; j++) begin : g_mux
      logic [IDX_W-1:0] sel;
      assign sel = sel_flat[j*IDX_W +: IDX_W];
      assign perm[j*ELEM_W +: ELEM_W] = src_arr[sel];
   end
endmodule

// File: rtl/qperm_wmask.sv
module qperm_wmask #(
   parameter int ELEM_W     = 64,
   parameter int HALF_ELEMS = 4,
   localparam int NUM_ELEMS = 2 * HALF_ELEMS,
   localparam int VEC_W     = ELEM_W * NUM_ELEMS
) (
   input  logic [VEC_W-1:0]     perm,
   input  logic [VEC_W-1:0]     old_dst,
   input  logic [NUM_ELEMS-1:0] wmask,
   input  logic                 mask_en,
   input  logic                 zero_mode,
   input  logic                 full_len,
   output logic [VEC_W-1:0]     result
);
   for (genvar j = 0; j < NUM_ELEMS; j++) begin : g_elem
      logic active;
      logic take;
      if (j < HALF_ELEMS) begin : g_low
         assign active = 1'b1;
      end else begin : g_high
         assign active = full_len;
      end
      assign take = ~mask_en | wmask[j];

      always_comb begin
         if (!active)
            result[j*ELEM_W +: ELEM_W] = '0;
         else if (take)
            result[j*ELEM_W +: ELEM_W] = perm[j*ELEM_W +: ELEM_W];
         else if (zero_mode)
            result[j*ELEM_W +: ELEM_W] = '0;
         else
            result[j*ELEM_W +: ELEM_W] = old_dst[j*ELEM_W +: ELEM_W];
      end
   end
endmodule

// File: rtl/qperm_legal.sv
module qperm_legal
   import qperm_pkg::*;
(
   input  logic       ctl_mode,
   input  logic [1:0] vlen,
   input  logic [3:0] rsv_spec,
   output logic       full_len,
   output logic       illegal
);
   logic len_bad;
   logic rsv_bad;

   always_comb begin
      unique case (vlen)
         VL_HALF: len_bad = 1'b0;
         VL_FULL: len_bad = 1'b0;
         default: len_bad = 1'b1;
      endcase
   end

   assign full_len = (vlen == VL_FULL);
   assign rsv_bad  = (ctl_mode == MODE_CTLBYTE) && (rsv_spec != RSV_EXPECT);
   assign illegal  = len_bad | rsv_bad;
endmodule

// File: rtl/qperm_unit.sv
module qperm_unit
   import qperm_pkg::*;
#(
   parameter int ELEM_W     = 64,
   parameter int HALF_ELEMS = 4,
   localparam int NUM_ELEMS = 2 * HALF_ELEMS,
   localparam int VEC_W     = ELEM_W * NUM_ELEMS,
   localparam int SEL_W     = $clog2(HALF_ELEMS),
   localparam int IDX_W     = SEL_W + 1,
   localparam int CTL_W     = SEL_W * HALF_ELEMS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 ctl_mode,
   input  logic [CTL_W-1:0]     ctl_byte,
   input  logic [VEC_W-1:0]     idx_vec,
   input  logic [VEC_W-1:0]     src_vec,
   input  logic                 bcast,
   input  logic                 src_is_mem,
   input  logic [NUM_ELEMS-1:0] wmask,
   input  logic                 mask_en,
   input  logic                 zero_mode,
   input  logic [VEC_W-1:0]     old_dst,
   input  logic [1:0]           vlen,
   input  logic [3:0]           rsv_spec,
   output logic                 out_valid,
   output logic [VEC_W-1:0]     out_vec,
   output logic                 out_wen,
   output logic                 out_illegal
);
   if (HALF_ELEMS < 2 || (HALF_ELEMS & (HALF_ELEMS - 1)) != 0) begin : g_bad_half
      $error("qperm_unit: HALF_ELEMS must be a power of two of at least 2");
   end
   if (ELEM_W < IDX_W) begin : g_bad_elem
      $error("qperm_unit: ELEM_W too narrow to carry an index");
   end

   logic                       full_len;
   logic                       illegal;
   logic [VEC_W-1:0]           eff_src;
   logic [NUM_ELEMS*IDX_W-1:0] sel_flat;
   logic [VEC_W-1:0]           perm;
   logic [VEC_W-1:0]           masked;

   qperm_legal u_legal (
      .ctl_mode (ctl_mode),
      .vlen     (vlen),
      .rsv_spec (rsv_spec),
      .full_len (full_len),
      .illegal  (illegal)
   );

   qperm_bcast #(.ELEM_W(ELEM_W), .NUM_ELEMS(NUM_ELEMS)) u_bcast (
      .src_vec    (src_vec),
      .bcast      (bcast),
      .src_is_mem (src_is_mem),
      .eff_src    (eff_src)
   );

   qperm_selgen #(.ELEM_W(ELEM_W), .HALF_ELEMS(HALF_ELEMS)) u_selgen (
      .ctl_mode (ctl_mode),
      .full_len (full_len),
      .ctl_byte (ctl_byte),
      .idx_vec  (idx_vec),
      .sel_flat (sel_flat)
   );

   qperm_xbar #(.ELEM_W(ELEM_W), .NUM_ELEMS(NUM_ELEMS)) u_xbar (
      .src      (eff_src),
      .sel_flat (sel_flat),
      .perm     (perm)
   );

   qperm_wmask #(.ELEM_W(ELEM_W), .HALF_ELEMS(HALF_ELEMS)) u_wmask (
      .perm      (perm),
      .old_dst   (old_dst),
      .wmask     (wmask),
      .mask_en   (mask_en),
      .zero_mode (zero_mode),
      .full_len  (full_len),
      .result    (masked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_vec     <= '0;
         out_wen     <= 1'b0;
         out_illegal <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         out_wen     <= in_valid & ~illegal;
         out_illegal <= in_valid & illegal;
         if (in_valid)
            out_vec <= illegal ? old_dst : masked;
      end
   end
endmodule

// File: rtl/qperm_unit_chk.sv
module qperm_unit_chk #(
   parameter int ELEM_W     = 64,
   parameter int HALF_ELEMS = 4,
   localparam int NUM_ELEMS = 2 * HALF_ELEMS,
   localparam int VEC_W     = ELEM_W * NUM_ELEMS,
   localparam int HALF_W    = ELEM_W * HALF_ELEMS,
   localparam int CTL_W     = $clog2(HALF_ELEMS) * HALF_ELEMS
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 ctl_mode,
   input logic [CTL_W-1:0]     ctl_byte,
   input logic [VEC_W-1:0]     idx_vec,
   input logic [VEC_W-1:0]     src_vec,
   input logic                 bcast,
   input logic                 src_is_mem,
   input logic [NUM_ELEMS-1:0] wmask,
   input logic                 mask_en,
   input logic                 zero_mode,
   input logic [VEC_W-1:0]     old_dst,
   input logic [1:0]           vlen,
   input logic [3:0]           rsv_spec,
   input logic                 out_valid,
   input logic [VEC_W-1:0]     out_vec,
   input logic                 out_wen,
   input logic                 out_illegal
);
   logic len_ok;
   logic rsv_ok;
   assign len_ok = (vlen == 2'b01) || (vlen == 2'b10);
   assign rsv_ok = ctl_mode || (rsv_spec == 4'b1111);

   // R10
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R10
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R10
   hold_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_vec));

   // R7
   bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !len_ok) |=> out_illegal);

   // R8
   bad_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !rsv_ok) |=> out_illegal);

   // R9
   illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !(len_ok && rsv_ok)) |=> (out_vec == $past(old_dst)) && !out_wen);

   // R9
   legal_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && len_ok && rsv_ok) |=> out_wen && !out_illegal);

   // R6
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vlen == 2'b01 && rsv_ok) |=> (out_vec[VEC_W-1:HALF_W] == '0));

   // R5
   zero_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && len_ok && rsv_ok && mask_en && zero_mode && wmask == '0)
      |=> (out_vec == '0));

   // R9
   wen_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_wen && out_illegal));
endmodule

bind qperm_unit qperm_unit_chk #(.ELEM_W(ELEM_W), .HALF_ELEMS(HALF_ELEMS)) u_chk (.*);

// File: tb/sim_qperm_unit.sv
module sim_qperm_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         ctl_mode = 1'b0;
   logic [7:0]   ctl_byte = '0;
   logic [511:0] idx_vec = '0;
   logic [511:0] src_vec = '0;
   logic         bcast = 1'b0;
   logic         src_is_mem = 1'b0;
   logic [7:0]   wmask = '0;
   logic         mask_en = 1'b0;
   logic         zero_mode = 1'b0;
   logic [511:0] old_dst = '0;
   logic [1:0]   vlen = 2'b10;
   logic [3:0]   rsv_spec = 4'hF;
   logic         out_valid;
   logic [511:0] out_vec;
   logic         out_wen;
   logic         out_illegal;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   qperm_unit u0 (.*);

   function automatic logic [63:0] mix(input int unsigned a);
      logic [31:0] p, q;
      p = a * 32'h9E3779B1;
      q = (a ^ 32'h5A5A1234) * 32'h85EBCA6B;
      return {p, q};
   endfunction

   function automatic void fill(input int unsigned seed);
      for (int k = 0; k < 8; k++) begin
         src_vec[k*64 +: 64] = mix(seed * 31 + k + 1);
         old_dst[k*64 +: 64] = mix(seed * 37 + k + 101);
         idx_vec[k*64 +: 64] = mix(seed * 41 + k + 211);
      end
   endfunction

   function automatic bit model_illegal();
      return !(vlen == 2'b01 || vlen == 2'b10) || (!ctl_mode && rsv_spec != 4'hF);
   endfunction

   function automatic logic [511:0] model_vec();
      logic [511:0] s, r;
      int full, sel;
      if (model_illegal()) return old_dst;
      full = (vlen == 2'b10) ? 1 : 0;
      for (int k = 0; k < 8; k++)
         s[k*64 +: 64] = (bcast && src_is_mem) ? src_vec[63:0] : src_vec[k*64 +: 64];
      for (int j = 0; j < 8; j++) begin
         if (ctl_mode)
            sel = full ? int'(idx_vec[j*64 +: 3]) : int'(idx_vec[j*64 +: 2]);
         else
            sel = (j / 4) * 4 + int'((ctl_byte >> (2 * (j % 4))) & 8'h3);
         if (j >= 4 && full == 0)       r[j*64 +: 64] = '0;
         else if (!mask_en || wmask[j]) r[j*64 +: 64] = s[sel*64 +: 64];
         else if (zero_mode)            r[j*64 +: 64] = '0;
         else                           r[j*64 +: 64] = old_dst[j*64 +: 64];
      end
      return r;
   endfunction

   task automatic run_op(input string req);
      logic [511:0] ev;
      bit           ei;
      ev = model_vec();
      ei = model_illegal();
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      n_checks++;
      if (out_vec !== ev || out_illegal !== ei || out_wen !== !ei || out_valid !== 1'b1) begin
         n_fail++;
         $display("FAIL %s: vec=%h ill=%b wen=%b vld=%b expected vec=%h ill=%b wen=%b vld=1",
                  req, out_vec, out_illegal, out_wen, out_valid, ev, ei, !ei);
      end
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [511:0] held;
      repeat (3) @(negedge clk);
      // R10 reset state
      n_checks++;
      if (out_valid !== 1'b0 || out_vec !== '0 || out_wen !== 1'b0 || out_illegal !== 1'b0) begin
         n_fail++;
         $display("FAIL R10 reset: vld=%b vec=%h wen=%b ill=%b expected all zero",
                  out_valid, out_vec, out_wen, out_illegal);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R11: every control byte at 512 bits
      ctl_mode = 1'b0; vlen = 2'b10; rsv_spec = 4'hF; mask_en = 1'b0;
      for (int c = 0; c < 256; c++) begin
         fill(c);
         ctl_byte = 8'(c);
         run_op("R1/R2/R11 ctlbyte 512");
      end
      // R1 R6: every control byte at 256 bits, merge mode with mask off
      vlen = 2'b01;
      for (int c = 0; c < 256; c++) begin
         fill(c + 300);
         ctl_byte = 8'(c);
         run_op("R1/R6 ctlbyte 256");
      end

      // R3: index vectors with junk upper bits; rsv ignored (R8)
      ctl_mode = 1'b1;
      for (int t = 0; t < 64; t++) begin
         fill(t + 700);
         rsv_spec = 4'(t);
         vlen = 2'b10;
         run_op("R3/R8 index 512");
         vlen = 2'b01;
         run_op("R3/R6 index 256");
      end
      rsv_spec = 4'hF;

      // R5: every mask, merge and zero, both lengths
      ctl_mode = 1'b0; ctl_byte = 8'h1B; mask_en = 1'b1;
      for (int m = 0; m < 256; m++) begin
         fill(m + 900);
         wmask = 8'(m);
         vlen = 2'b10;
         zero_mode = 1'b0; run_op("R5 merge 512");
         zero_mode = 1'b1; run_op("R5 zero 512");
         vlen = 2'b01;
         zero_mode = 1'b0; run_op("R5/R6 merge 256");
      end
      // R5: mask disabled ignores wmask
      mask_en = 1'b0; wmask = 8'h00; zero_mode = 1'b1; vlen = 2'b10;
      fill(1234);
      run_op("R5 mask off");

      // R4: broadcast combinations
      ctl_mode = 1'b1;
      for (int b = 0; b < 4; b++) begin
         fill(b + 1500);
         bcast = b[0]; src_is_mem = b[1];
         vlen = 2'b10; run_op("R4 broadcast 512");
         vlen = 2'b01; run_op("R4 broadcast 256");
      end
      bcast = 1'b0; src_is_mem = 1'b0;

      // R7 R9: illegal lengths in both modes
      for (int md = 0; md < 2; md++) begin
         ctl_mode = md[0];
         fill(md + 1700);
         vlen = 2'b00; run_op("R7/R9 len 128");
         vlen = 2'b11; run_op("R7/R9 len rsvd");
      end

      // R8 R9: every reserved field value in control-byte mode
      ctl_mode = 1'b0; vlen = 2'b10; ctl_byte = 8'hE4;
      for (int r = 0; r < 16; r++) begin
         fill(r + 1800);
         rsv_spec = 4'(r);
         run_op("R8/R9 rsv field");
      end
      rsv_spec = 4'hF;

      // R10: output holds and valid drops with no strobe
      fill(2000);
      run_op("R10 strobe");
      held = out_vec;
      fill(2001);
      @(negedge clk);
      n_checks++;
      if (out_valid !== 1'b0 || out_vec !== held) begin
         n_fail++;
         $display("FAIL R10 idle: vld=%b vec=%h expected vld=0 vec=%h", out_valid, out_vec, held);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule